// File: doc/BRIEF.md
# Thresholded Input Level Detector

This block estimates how strong a sampled IF input is over a chosen window, so that an external gain loop can steer an analog IF amplifier. Every enabled input sample is reduced to its magnitude and compared with a programmable threshold. Samples at or above the threshold add to an accumulator. In counting mode each one adds 1, and the result is the number of exceedances. In magnitude mode each one adds its own magnitude.

The window length is set in enabled samples by an 18-bit preload. A configuration bit can force the two low preload bits to one, and then the window is an exact multiple of four samples. A start pulse opens the window. When the window ends, the accumulator total is latched into a holding register and a ready flag rises for the processor. In single mode the detector then goes idle. In continuous mode it reopens the window at once with a cleared accumulator. A read pulse clears the ready flag.

Top module: `if_level_meter`

## Requirements
- R1: After reset, `resultReady` is 0, `levelResult` is 0 and the detector is idle.
- R2: The effective preload P counts enabled samples. A window holds exactly P+1 enabled samples. The total, including the last sample, appears on `levelResult` and `resultReady` goes to 1 on the clock edge that takes the last sample. `resultReady` stays 0 before that edge.
- R3: When `forceLsbOnes` is 1, P is `periodPreload` with bits 1 and 0 replaced by ones. When `forceLsbOnes` is 0, P equals `periodPreload`.
- R4: With `magMode` = 0, each enabled sample whose magnitude is at least `threshold` adds 1. Samples below the threshold add 0. Samples are 14-bit two's complement.
- R5: With `magMode` = 1, each enabled sample whose magnitude is at least `threshold` adds its magnitude. The magnitude of -8192 is 8192.
- R6: With `contMode` = 0, the detector goes idle after one window. Later samples change neither `levelResult` nor `resultReady`.
- R7: With `contMode` = 1, a new window of P+1 samples begins right after each one ends, with the accumulator cleared.
- R8: A `resultRead` pulse clears `resultReady` on the next edge. If a window ends on the same edge, `resultReady` stays 1.
- R9: A window that ends while `resultReady` is still 1 overwrites `levelResult` with the new total.
- R10: A `startPulse` clears the accumulator and reloads the window from P, even while a window is already running. A sample presented on the same cycle as `startPulse` is dropped.
- R11: Cycles with `sampleValid` = 0 neither add to the total nor advance the window.
- R12: Before the first `startPulse`, samples have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 14 | Two's complement IF sample |
| sampleValid | input | 1 | Sample enable |
| threshold | input | 14 | Magnitude threshold for the gating stage |
| periodPreload | input | 18 | Window preload P |
| forceLsbOnes | input | 1 | Forces bits 1:0 of P to ones |
| contMode | input | 1 | 1 = continuous windows, 0 = single window |
| magMode | input | 1 | 1 = accumulate magnitude, 0 = count exceedances |
| startPulse | input | 1 | Opens or restarts a window |
| resultRead | input | 1 | Processor read strobe; clears the ready flag |
| levelResult | output | 32 | Total latched from the last completed window |
| resultReady | output | 1 | A new result is waiting to be read |

## Verification
The hardest conditions to create from the ports are the ones that need edge-exact timing: a read strobe that lands on the same edge as the end of a window, and a restart that arrives partway through a window. The stimulus tasks present every input for exactly one cycle. This lets the bench place the read on the last sample of a continuous window. It also lets the bench issue a second start after two of three samples, and then show that three more samples are needed before the result appears.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  typedef struct packed {
    logic clrAcc;
    logic accEn;
    logic capture;
  } lvl_strobe_t;
endpackage

// File: rtl/lvl_dpath.sv
module lvl_dpath
  import lvl_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic        [DATA_W-1:0] threshold,
  input  logic                     magMode,
  input  lvl_strobe_t              strobes,
  output logic        [ACC_W-1:0]  accVal,
  output logic        [ACC_W-1:0]  holdVal
);
  logic [DATA_W-1:0] mag;
  logic              hit;
  logic [ACC_W-1:0]  contrib;
  logic [ACC_W-1:0]  sum;

  always_comb begin
    mag = sampleIn[DATA_W-1] ? DATA_W'(-sampleIn) : DATA_W'(sampleIn);
    hit = (mag >= threshold);
    if (!hit)         contrib = '0;
    else if (magMode) contrib = ACC_W'(mag);
    else              contrib = ACC_W'(1);
    sum = accVal + contrib;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accVal  <= '0;
      holdVal <= '0;
    end else if (strobes.clrAcc) begin
      accVal <= '0;
    end else if (strobes.capture) begin
      holdVal <= sum;
      accVal  <= '0;
    end else if (strobes.accEn) begin
      accVal <= sum;
    end
  end
endmodule

// File: rtl/lvl_ctrl.sv
module lvl_ctrl
  import lvl_pkg::*;
#(
  parameter int CNT_W      = 18,
  parameter int FORCE_BITS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [CNT_W-1:0] periodPreload,
  input  logic             forceLsbOnes,
  input  logic             contMode,
  input  logic             startPulse,
  input  logic             resultRead,
  output lvl_strobe_t      strobes,
  output logic             active,
  output logic             resultReady
);
  localparam logic [CNT_W-1:0] FORCE_MASK = CNT_W'((1 << FORCE_BITS) - 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] periodEff;
  logic             lastSample;

  always_comb begin
    periodEff  = forceLsbOnes ? (periodPreload | FORCE_MASK) : periodPreload;
    lastSample = (count == '0);
    strobes    = '0;
    if (startPulse) begin
      strobes.clrAcc = 1'b1;
    end else if (active && sampleValid) begin
      strobes.accEn   = 1'b1;
      strobes.capture = lastSample;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active      <= 1'b0;
      count       <= '0;
      resultReady <= 1'b0;
    end else begin
      if (startPulse) begin
        active <= 1'b1;
        count  <= periodEff;
      end else if (active && sampleValid) begin
        if (lastSample) begin
          active <= contMode;
          count  <= periodEff;
        end else begin
          count <= count - 1'b1;
        end
      end
      if (strobes.capture)  resultReady <= 1'b1;
      else if (resultRead)  resultReady <= 1'b0;
    end
  end
endmodule

// File: rtl/if_level_meter.sv
module if_level_meter
  import lvl_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int CNT_W  = 18,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic                     sampleValid,
  input  logic        [DATA_W-1:0] threshold,
  input  logic        [CNT_W-1:0]  periodPreload,
  input  logic                     forceLsbOnes,
  input  logic                     contMode,
  input  logic                     magMode,
  input  logic                     startPulse,
  input  logic                     resultRead,
  output logic        [ACC_W-1:0]  levelResult,
  output logic                     resultReady
);
  lvl_strobe_t      strobes;
  logic             active;
  logic [ACC_W-1:0] accVal;

  lvl_ctrl #(.CNT_W(CNT_W), .FORCE_BITS(2)) ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .periodPreload(periodPreload), .forceLsbOnes(forceLsbOnes),
    .contMode(contMode), .startPulse(startPulse), .resultRead(resultRead),
    .strobes(strobes), .active(active), .resultReady(resultReady)
  );

  lvl_dpath #(.DATA_W(DATA_W), .ACC_W(ACC_W)) dpath (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .threshold(threshold),
    .magMode(magMode), .strobes(strobes), .accVal(accVal),
    .holdVal(levelResult)
  );
endmodule

// File: rtl/lvl_checker.sv
module lvl_checker #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic             resultRead,
  input logic             resultReady,
  input logic [ACC_W-1:0] levelResult,
  input logic             active,
  input logic             capture,
  input logic [ACC_W-1:0] accVal
);
  assert_ready_after_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> resultReady);

  assert_ready_drop_needs_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resultReady) |-> $past(resultRead));

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !capture |=> $stable(levelResult));

  assert_idle_no_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !capture);

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (accVal == '0) && active);
endmodule

bind if_level_meter lvl_checker #(.ACC_W(ACC_W)) chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .resultRead(resultRead),
  .resultReady(resultReady), .levelResult(levelResult), .active(active),
  .capture(strobes.capture), .accVal(accVal)
);

// File: tb/if_level_meter_test.sv
module if_level_meter_test;
  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic signed [13:0] sampleIn = '0;
  logic               sampleValid = 1'b0;
  logic        [13:0] threshold = '0;
  logic        [17:0] periodPreload = '0;
  logic               forceLsbOnes = 1'b0;
  logic               contMode = 1'b0;
  logic               magMode = 1'b0;
  logic               startPulse = 1'b0;
  logic               resultRead = 1'b0;
  logic        [31:0] levelResult;
  logic               resultReady;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  if_level_meter uut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .threshold(threshold), .periodPreload(periodPreload),
    .forceLsbOnes(forceLsbOnes), .contMode(contMode), .magMode(magMode),
    .startPulse(startPulse), .resultRead(resultRead),
    .levelResult(levelResult), .resultReady(resultReady)
  );

  typedef struct packed {
    logic [17:0]        pre;
    logic               frc;
    logic               mag;
    logic [13:0]        thr;
    logic signed [13:0] base;
    logic signed [13:0] stp;
    logic [31:0]        expv;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{18'd3, 1'b0, 1'b0, 14'd10,   -14'sd20,   14'sd10, 32'd3},
    '{18'd3, 1'b0, 1'b1, 14'd10,   -14'sd20,   14'sd10, 32'd40},
    '{18'd4, 1'b1, 1'b0, 14'd0,     14'sd1,    14'sd0,  32'd8},
    '{18'd0, 1'b1, 1'b1, 14'd5,    -14'sd8192, 14'sd0,  32'd32768},
    '{18'd5, 1'b0, 1'b1, 14'd100,   14'sd3,    14'sd40, 32'd489},
    '{18'd0, 1'b0, 1'b0, 14'd8191,  14'sd8191, 14'sd0,  32'd1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    testsRun++;
    if (act !== expv) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic cyc(input logic signed [13:0] x, input logic v, input logic st, input logic rd);
    @(negedge clk);
    sampleIn = x; sampleValid = v; startPulse = st; resultRead = rd;
    @(negedge clk);
    sampleValid = 1'b0; startPulse = 1'b0; resultRead = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 ready after reset", 32'(resultReady), 0);
    check("R1 result after reset", levelResult, 0);

    // R12: samples before any start are ignored
    for (int i = 0; i < 4; i++) cyc(14'sd500, 1'b1, 1'b0, 1'b0);
    check("R12 no ready without start", 32'(resultReady), 0);
    check("R12 no result without start", levelResult, 0);

    // table-driven single-mode windows (R2 R3 R4 R5 R6 R11)
    for (int k = 0; k < 6; k++) begin
      int n;
      periodPreload = VEC[k].pre; forceLsbOnes = VEC[k].frc;
      magMode = VEC[k].mag; threshold = VEC[k].thr; contMode = 1'b0;
      n = VEC[k].frc ? int'({VEC[k].pre[17:2], 2'b11}) + 1 : int'(VEC[k].pre) + 1;
      cyc(14'sd0, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < n; i++) begin
        cyc(14'(VEC[k].base + 14'(i) * VEC[k].stp), 1'b1, 1'b0, 1'b0);
        cyc(14'sd8000, 1'b0, 1'b0, 1'b0);  // R11 disabled sample
        if (i == n - 2) check("R2 not ready before last sample", 32'(resultReady), 0);
      end
      check("R2 ready at window end", 32'(resultReady), 1);
      check("R4 R5 R3 window total", levelResult, VEC[k].expv);
      cyc(14'sd0, 1'b0, 1'b0, 1'b1);
      check("R8 read clears ready", 32'(resultReady), 0);
      for (int i = 0; i < 3; i++) cyc(14'sd4000, 1'b1, 1'b0, 1'b0);
      check("R6 idle keeps ready low", 32'(resultReady), 0);
      check("R6 idle keeps result", levelResult, VEC[k].expv);
    end

    // R7 R9 R8 continuous windows of 2 samples, magnitude mode
    periodPreload = 18'd1; forceLsbOnes = 1'b0; magMode = 1'b1;
    threshold = 14'd0; contMode = 1'b1;
    cyc(14'sd0, 1'b0, 1'b1, 1'b0);
    cyc(14'sd1, 1'b1, 1'b0, 1'b0);
    cyc(-14'sd2, 1'b1, 1'b0, 1'b0);
    check("R7 first window", levelResult, 3);
    cyc(14'sd0, 1'b0, 1'b0, 1'b1);
    cyc(14'sd5, 1'b1, 1'b0, 1'b0);
    cyc(14'sd6, 1'b1, 1'b0, 1'b0);
    check("R7 restart with cleared accumulator", levelResult, 11);
    cyc(14'sd7, 1'b1, 1'b0, 1'b0);
    cyc(14'sd8, 1'b1, 1'b0, 1'b0);
    check("R9 overwrite unread result", levelResult, 15);
    check("R9 ready still set", 32'(resultReady), 1);
    cyc(14'sd1, 1'b1, 1'b0, 1'b0);
    cyc(14'sd1, 1'b1, 1'b0, 1'b1);  // read on the same edge as window end
    check("R8 capture wins over read", 32'(resultReady), 1);
    check("R8 result of collided window", levelResult, 2);
    cyc(14'sd0, 1'b0, 1'b0, 1'b1);
    check("R8 later read clears", 32'(resultReady), 0);

    // R10 restart mid-window, 3-sample single window
    contMode = 1'b0; periodPreload = 18'd2;
    cyc(14'sd0, 1'b0, 1'b1, 1'b0);
    cyc(14'sd100, 1'b1, 1'b0, 1'b0);
    cyc(14'sd100, 1'b1, 1'b0, 1'b0);
    cyc(14'sd900, 1'b1, 1'b1, 1'b0);  // sample dropped with start
    cyc(14'sd1, 1'b1, 1'b0, 1'b0);
    cyc(14'sd2, 1'b1, 1'b0, 1'b0);
    check("R10 window reloaded", 32'(resultReady), 0);
    cyc(14'sd3, 1'b1, 1'b0, 1'b0);
    check("R10 restart ready", 32'(resultReady), 1);
    check("R10 restart total", levelResult, 6);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule